// File: doc/BRIEF.md
# Low-Power SDR SDRAM Power-Up Initialization Sequencer

This block brings a low-power single-data-rate SDRAM from reset to a usable state. From the moment reset is applied it drives clock enable and every data mask high and puts NOP on the command pins. After reset is released it issues NOP for a settle interval of at least 200 µs. The interval is converted to clock cycles from a clock-frequency parameter, rounding up.

It then closes every bank with a precharge-all and issues two auto-refresh commands. After that it loads the mode register and, unless a parameter skips it, the extended mode register. Each command stands on the pins for one cycle and is followed by a NOP gap of its parameterized length. When the last gap has elapsed a done flag rises and stays high until the next reset.

The mode word is assembled from parameters. Only CAS latencies 2 and 3 are accepted. Any other value raises a configuration-error output, and the sequencer then stops after the refreshes without ever loading a register. The controller behind this block starts normal traffic once the done flag is high.

Top module: `lpsdr_init_seq`

## Requirements
- R1: Clock enable and all data-mask bits are high during reset and in every cycle after it. Done is low during reset.
- R2: After reset release only NOP is issued for SETTLE_CYC = ceil(SETTLE_US*CLK_KHZ/1000) cycles. Counting sampled cycles after release from 1, the first command appears in cycle SETTLE_CYC+1.
- R3: The first command is precharge-all. It is encoded as {csN,rasN,casN,weN}=0010 with address bit 10 high, all other address bits low and bank select 00.
- R4: Two auto-refresh commands (0001) follow. The first comes T_RP+1 cycles after the precharge, and the second comes T_RFC+1 cycles after the first.
- R5: T_RFC+1 cycles after the second refresh, a load-mode command (0000) is issued with bank select 00. Its address word carries the burst length code on A2:A0, the burst type on A3 (0 sequential, 1 interleaved), the CAS latency code on A6:A4 and the write-single bit on A9; all other bits are 0.
- R6: Unless SKIP_EXT is set, a load-mode command with bank select 10 and address EXT_WORD is issued T_MRD+1 cycles after the mode-register load. With SKIP_EXT set no such command ever appears.
- R7: Done rises T_MRD+1 cycles after the last register-load command and then stays high until reset.
- R8: If CAS_LATENCY is neither 2 nor 3, cfgErr is high, no load-mode command is ever issued and done never rises. Otherwise cfgErr is low.
- R9: In every cycle without a command, the pins show NOP (0111) with bank select and address all zero.
- R10: Asserting reset part-way through the sequence returns the pins to the reset state, and the full sequence restarts from the settle interval on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | ADDR_W | Address bus |
| dqm | output | DQM_W | Data masks |
| initDone | output | 1 | Initialization complete, sticky |
| cfgErr | output | 1 | Reserved CAS latency configured |

## Verification
The bench runs three configurations side by side and compares the pins against an arithmetically computed timeline in every cycle.

- The first configuration uses CAS 2, sequential bursts and both register loads. It checks the basic command order and the gap lengths.
- The second uses CAS 3, interleaved bursts and single writes, skips the extended register, and has a frequency where the rounding-up of the settle count matters. It tells apart correct field packing, the skip path and correct ceiling arithmetic.
- The third uses a reserved CAS value. It separates the halt path from the normal path.

A reset part-way through the run shows that the sequence restarts from the beginning.

// File: rtl/lpsdr_init_pkg.sv
package lpsdr_init_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE, ST_PRE, ST_WPRE, ST_REF, ST_WREF,
    ST_MRS, ST_WMRS, ST_EMRS, ST_WEMRS, ST_DONE, ST_HALT
  } initState_e;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic issueEmrs;
    logic markDone;
  } initStrobes_t;

  function automatic logic casSupported(input int casLat);
    return (casLat == 2) || (casLat == 3);
  endfunction

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lpsdr_init_ctrl.sv
module lpsdr_init_ctrl
  import lpsdr_init_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int SETTLE_US   = 200,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 10,
  parameter int T_MRD       = 2,
  parameter int CAS_LATENCY = 3,
  parameter bit SKIP_EXT    = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  output initStrobes_t strobes
);

  localparam int SETTLE_CYC = ceilDiv(SETTLE_US * CLK_KHZ, 1000);
  localparam int MAX_A      = (SETTLE_CYC > T_RFC) ? SETTLE_CYC : T_RFC;
  localparam int MAX_B      = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam bit CFG_OK     = casSupported(CAS_LATENCY);

  initState_e  state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic        secondRef, nextSecondRef;
  logic        cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    nextState     = state;
    nextCnt       = cntZero ? cnt : cnt - 1'b1;
    nextSecondRef = secondRef;
    unique case (state)
      ST_SETTLE: if (cntZero) nextState = ST_PRE;
      ST_PRE: begin
        nextCnt   = CNT_W'(T_RP - 1);
        nextState = ST_WPRE;
      end
      ST_WPRE: if (cntZero) nextState = ST_REF;
      ST_REF: begin
        nextCnt   = CNT_W'(T_RFC - 1);
        nextState = ST_WREF;
      end
      ST_WREF: if (cntZero) begin
        if (!secondRef) begin
          nextSecondRef = 1'b1;
          nextState     = ST_REF;
        end else if (CFG_OK) begin
          nextState = ST_MRS;
        end else begin
          nextState = ST_HALT;
        end
      end
      ST_MRS: begin
        nextCnt   = CNT_W'(T_MRD - 1);
        nextState = ST_WMRS;
      end
      ST_WMRS: if (cntZero) nextState = SKIP_EXT ? ST_DONE : ST_EMRS;
      ST_EMRS: begin
        nextCnt   = CNT_W'(T_MRD - 1);
        nextState = ST_WEMRS;
      end
      ST_WEMRS: if (cntZero) nextState = ST_DONE;
      ST_DONE:  nextState = ST_DONE;
      default:  nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      cnt       <= CNT_W'(SETTLE_CYC - 1);
      secondRef <= 1'b0;
    end else begin
      state     <= nextState;
      cnt       <= nextCnt;
      secondRef <= nextSecondRef;
    end
  end

  always_comb begin
    strobes.issuePre  = (state == ST_PRE);
    strobes.issueRef  = (state == ST_REF);
    strobes.issueMrs  = (state == ST_MRS);
    strobes.issueEmrs = (state == ST_EMRS);
    strobes.markDone  = (state == ST_DONE);
  end

endmodule

// File: rtl/lpsdr_init_dp.sv
module lpsdr_init_dp
  import lpsdr_init_pkg::*;
#(
  parameter int              ADDR_W         = 12,
  parameter int              DQM_W          = 2,
  parameter logic [2:0]      BURST_LEN_CODE = 3'b011,
  parameter bit              BURST_TYPE     = 1'b0,
  parameter int              CAS_LATENCY    = 3,
  parameter bit              WRITE_SINGLE   = 1'b0,
  parameter logic [ADDR_W-1:0] EXT_WORD     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  initStrobes_t      strobes,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              initDone
);

  localparam logic [2:0] CAS_CODE = 3'(CAS_LATENCY);

  function automatic logic [ADDR_W-1:0] packMode();
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = BURST_LEN_CODE;
    w[3]   = BURST_TYPE;
    w[6:4] = CAS_CODE;
    w[9]   = WRITE_SINGLE;
    return w;
  endfunction

  localparam logic [ADDR_W-1:0] MODE_WORD = packMode();

  logic [3:0]        cmdNext;
  logic [1:0]        baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    cmdNext  = 4'b0111;
    baNext   = 2'b00;
    addrNext = '0;
    if (strobes.issuePre) begin
      cmdNext      = 4'b0010;
      addrNext[10] = 1'b1;
    end else if (strobes.issueRef) begin
      cmdNext = 4'b0001;
    end else if (strobes.issueMrs) begin
      cmdNext  = 4'b0000;
      addrNext = MODE_WORD;
    end else if (strobes.issueEmrs) begin
      cmdNext  = 4'b0000;
      baNext   = 2'b10;
      addrNext = EXT_WORD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke                    <= 1'b1;
      dqm                    <= '1;
      {csN, rasN, casN, weN} <= 4'b0111;
      ba                     <= 2'b00;
      addr                   <= '0;
      initDone               <= 1'b0;
    end else begin
      cke                    <= 1'b1;
      dqm                    <= '1;
      {csN, rasN, casN, weN} <= cmdNext;
      ba                     <= baNext;
      addr                   <= addrNext;
      initDone               <= initDone | strobes.markDone;
    end
  end

endmodule

// File: rtl/lpsdr_init_seq.sv
module lpsdr_init_seq
  import lpsdr_init_pkg::*;
#(
  parameter int              ADDR_W         = 12,
  parameter int              DQM_W          = 2,
  parameter int              CLK_KHZ        = 125000,
  parameter int              SETTLE_US      = 200,
  parameter int              T_RP           = 3,
  parameter int              T_RFC          = 10,
  parameter int              T_MRD          = 2,
  parameter logic [2:0]      BURST_LEN_CODE = 3'b011,
  parameter bit              BURST_TYPE     = 1'b0,
  parameter int              CAS_LATENCY    = 3,
  parameter bit              WRITE_SINGLE   = 1'b0,
  parameter bit              SKIP_EXT       = 1'b0,
  parameter logic [ADDR_W-1:0] EXT_WORD     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              initDone,
  output logic              cfgErr
);

  initStrobes_t strobes;

  assign cfgErr = !casSupported(CAS_LATENCY);

  lpsdr_init_ctrl #(
    .CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .CAS_LATENCY(CAS_LATENCY), .SKIP_EXT(SKIP_EXT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes)
  );

  lpsdr_init_dp #(
    .ADDR_W(ADDR_W), .DQM_W(DQM_W), .BURST_LEN_CODE(BURST_LEN_CODE),
    .BURST_TYPE(BURST_TYPE), .CAS_LATENCY(CAS_LATENCY),
    .WRITE_SINGLE(WRITE_SINGLE), .EXT_WORD(EXT_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr), .dqm(dqm),
    .initDone(initDone)
  );

endmodule

// File: rtl/lpsdr_init_chk.sv
module lpsdr_init_chk #(
  parameter int ADDR_W = 12,
  parameter int DQM_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              initDone,
  input logic              cfgErr
);

  logic [3:0] cmd;
  logic       isNop, isPre, isLoad;
  assign cmd    = {csN, rasN, casN, weN};
  assign isNop  = (cmd == 4'b0111);
  assign isPre  = (cmd == 4'b0010);
  assign isLoad = (cmd == 4'b0000);

  a_r1_cke_dqm_high: assert property (@(posedge clk) disable iff (!rstN)
    cke && (&dqm));

  a_r3_pre_all_form: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (addr[10] && ba == 2'b00));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r8_no_load_on_err: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!isLoad && !initDone));

  a_r9_cmd_then_nop: assert property (@(posedge clk) disable iff (!rstN)
    !isNop |=> isNop);

  a_r9_nop_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    isNop |-> (addr == '0 && ba == 2'b00));

  a_r5_load_bank: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |-> (ba == 2'b00 || ba == 2'b10));

endmodule

bind lpsdr_init_seq lpsdr_init_chk #(.ADDR_W(ADDR_W), .DQM_W(DQM_W)) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .addr(addr), .dqm(dqm), .initDone(initDone),
  .cfgErr(cfgErr)
);

// File: tb/lpsdr_init_seq_bench.sv
module lpsdr_init_seq_bench;

  localparam int NCFG = 3;
  localparam int AW   = 12;

  localparam int KHZ  [NCFG] = '{1000, 333, 500};
  localparam int TRP  [NCFG] = '{2, 3, 2};
  localparam int TRFC [NCFG] = '{5, 7, 5};
  localparam int TMRD [NCFG] = '{2, 3, 2};
  localparam int CASL [NCFG] = '{2, 3, 4};
  localparam bit SKIP [NCFG] = '{1'b0, 1'b1, 1'b0};
  localparam logic [2:0] BLC [NCFG] = '{3'b011, 3'b010, 3'b001};
  localparam bit BT   [NCFG] = '{1'b0, 1'b1, 1'b0};
  localparam bit WS   [NCFG] = '{1'b0, 1'b1, 1'b0};
  localparam logic [AW-1:0] EXTW [NCFG] = '{12'h020, 12'h000, 12'h040};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          cke   [NCFG];
  logic [3:0]    cmd   [NCFG];
  logic [1:0]    ba    [NCFG];
  logic [AW-1:0] addr  [NCFG];
  logic [1:0]    dqm   [NCFG];
  logic          done  [NCFG];
  logic          err   [NCFG];

  int total = 0;
  int bad   = 0;
  bit hung  = 1'b0;

  lpsdr_init_seq #(
    .ADDR_W(AW), .CLK_KHZ(KHZ[0]), .T_RP(TRP[0]), .T_RFC(TRFC[0]),
    .T_MRD(TMRD[0]), .BURST_LEN_CODE(BLC[0]), .BURST_TYPE(BT[0]),
    .CAS_LATENCY(CASL[0]), .WRITE_SINGLE(WS[0]), .SKIP_EXT(SKIP[0]),
    .EXT_WORD(EXTW[0])
  ) u_lpsdr_init_seq (
    .clk(clk), .rstN(rstN), .cke(cke[0]), .csN(cmd[0][3]), .rasN(cmd[0][2]),
    .casN(cmd[0][1]), .weN(cmd[0][0]), .ba(ba[0]), .addr(addr[0]),
    .dqm(dqm[0]), .initDone(done[0]), .cfgErr(err[0])
  );

  lpsdr_init_seq #(
    .ADDR_W(AW), .CLK_KHZ(KHZ[1]), .T_RP(TRP[1]), .T_RFC(TRFC[1]),
    .T_MRD(TMRD[1]), .BURST_LEN_CODE(BLC[1]), .BURST_TYPE(BT[1]),
    .CAS_LATENCY(CASL[1]), .WRITE_SINGLE(WS[1]), .SKIP_EXT(SKIP[1]),
    .EXT_WORD(EXTW[1])
  ) u_lpsdr_init_seq_b (
    .clk(clk), .rstN(rstN), .cke(cke[1]), .csN(cmd[1][3]), .rasN(cmd[1][2]),
    .casN(cmd[1][1]), .weN(cmd[1][0]), .ba(ba[1]), .addr(addr[1]),
    .dqm(dqm[1]), .initDone(done[1]), .cfgErr(err[1])
  );

  lpsdr_init_seq #(
    .ADDR_W(AW), .CLK_KHZ(KHZ[2]), .T_RP(TRP[2]), .T_RFC(TRFC[2]),
    .T_MRD(TMRD[2]), .BURST_LEN_CODE(BLC[2]), .BURST_TYPE(BT[2]),
    .CAS_LATENCY(CASL[2]), .WRITE_SINGLE(WS[2]), .SKIP_EXT(SKIP[2]),
    .EXT_WORD(EXTW[2])
  ) u_lpsdr_init_seq_c (
    .clk(clk), .rstN(rstN), .cke(cke[2]), .csN(cmd[2][3]), .rasN(cmd[2][2]),
    .casN(cmd[2][1]), .weN(cmd[2][0]), .ba(ba[2]), .addr(addr[2]),
    .dqm(dqm[2]), .initDone(done[2]), .cfgErr(err[2])
  );

  function automatic logic [AW-1:0] modeWord(int i);
    logic [AW-1:0] w = '0;
    w[2:0] = BLC[i];
    w[3]   = BT[i];
    w[6:4] = 3'(CASL[i]);
    w[9]   = WS[i];
    return w;
  endfunction

  function automatic bit cfgBad(int i);
    return !(CASL[i] == 2 || CASL[i] == 3);
  endfunction

  task automatic check(bit ok, string req, int i, int n, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cfg=%0d cycle=%0d actual=%0h expected=%0h", req, i, n, act, exp);
    end
  endtask

  task automatic checkReset(string req);
    for (int i = 0; i < NCFG; i++) begin
      check(cke[i] && dqm[i] == 2'b11, "R1", i, 0, {cke[i], dqm[i]}, 3'b111);
      check(cmd[i] == 4'b0111 && ba[i] == 2'b00 && addr[i] == '0, req, i, 0,
            {cmd[i], ba[i], addr[i]}, {4'b0111, 14'h0});
      check(done[i] == 1'b0, req, i, 0, done[i], 0);
    end
  endtask

  task automatic checkCycle(int n);
    for (int i = 0; i < NCFG; i++) begin
      int sc  = (200 * KHZ[i] + 999) / 1000;
      int pre = sc + 1;
      int r1  = pre + TRP[i] + 1;
      int r2  = r1 + TRFC[i] + 1;
      int m1  = r2 + TRFC[i] + 1;
      int e1  = m1 + TMRD[i] + 1;
      int dn  = SKIP[i] ? e1 : e1 + TMRD[i] + 1;
      logic [3:0]    eCmd  = 4'b0111;
      logic [1:0]    eBa   = 2'b00;
      logic [AW-1:0] eAddr = '0;
      logic          eDone = 1'b0;
      string         req   = (n < pre) ? "R2" : (cfgBad(i) ? "R8" : "R9");
      if (n == pre) begin eCmd = 4'b0010; eAddr[10] = 1'b1; req = "R3"; end
      if (n == r1 || n == r2) begin eCmd = 4'b0001; req = "R4"; end
      if (!cfgBad(i)) begin
        if (n == m1) begin eCmd = 4'b0000; eAddr = modeWord(i); req = "R5"; end
        if (n == e1) begin
          req = "R6";
          if (!SKIP[i]) begin eCmd = 4'b0000; eBa = 2'b10; eAddr = EXTW[i]; end
        end
        eDone = (n >= dn);
      end
      check(cke[i] && dqm[i] == 2'b11, "R1", i, n, {cke[i], dqm[i]}, 3'b111);
      check(cmd[i] == eCmd && ba[i] == eBa && addr[i] == eAddr, req, i, n,
            {cmd[i], ba[i], addr[i]}, {eCmd, eBa, eAddr});
      check(done[i] == eDone, cfgBad(i) ? "R8" : "R7", i, n, done[i], eDone);
    end
  endtask

  initial begin
    #1_000_000;
    hung = 1'b1;
  end

  initial begin
    for (int k = 0; k < 3; k++) @(negedge clk);
    checkReset("R1");
    for (int i = 0; i < NCFG; i++)
      check(err[i] == cfgBad(i), "R8", i, 0, err[i], cfgBad(i));
    rstN = 1'b1;
    for (int n = 1; n <= 120 && !hung; n++) begin
      @(negedge clk);
      checkCycle(n);
    end
    rstN = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checkReset("R10");
    end
    rstN = 1'b1;
    for (int n = 1; n <= 300 && !hung; n++) begin
      @(negedge clk);
      checkCycle(n);
    end
    if (hung) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule